// File: doc/BRIEF.md
# Serial Dot-Matrix Display Initializer and Loader

This block sits on the host side of a chain of 5x7 LED matrix driver devices and produces every line those devices need: an active-low device reset, an active-low enable, a register select, a serial clock and serial data. After the system reset is released it runs a fixed start-up sequence by itself. It pulses the device reset, shifts zeros through the whole dot chain so that no random pattern shows, and then writes the brightness control word with the wake bit set. Only then does it report itself idle.

Once idle it takes one request at a time through a valid/busy/done handshake. A frame request names a base address in a column buffer. The block reads one byte per character column, in sequence from that base, and shifts each byte out. A control request carries one byte, which is shifted out with register select high. Every waveform phase is timed in system clock cycles: clock high, clock low, a setup/hold gap around the enable edges, and the reset pulse width. All of these are parameters, so the device minimums can be met at any system clock rate.

The controller is one state machine. Its states are RESET_PULSE, RS_SETUP, CE_FALL, CLK_LOW, CLK_HIGH, CE_RISE, LATCH and IDLE. The transitions are:
- RESET_PULSE→RS_SETUP when the pulse timer ends.
- RS_SETUP→CE_FALL and CE_FALL→CLK_LOW (first byte loaded) on timer end.
- CLK_LOW→CLK_HIGH on timer end.
- CLK_HIGH→CLK_LOW when bits remain (shift, or load the next byte), or CLK_HIGH→CE_RISE after the last bit.
- CE_RISE→LATCH on timer end.
- LATCH→RS_SETUP for the start-up control write after the start-up clear, or LATCH→IDLE otherwise.
- IDLE→RS_SETUP when a request is accepted.

Top module: `dotmatrix_loader`

## Requirements
- R1: While `rst_n` is low and for exactly T_RST cycles after it rises, `disp_rst_n` is low. It never falls again afterwards, and `busy` stays high until start-up completes.
- R2: The first transfer after the device reset has `disp_rs` low and shifts N_DEV*CHARS_PER_DEV*COLS_PER_CHAR*8 zero bits, then latches.
- R3: The second transfer has `disp_rs` high and shifts the 8 bits 0,1,BOOT_LEVEL[5:0], most significant first (bit 7 = word select 0, bit 6 = wake). The block then goes idle without pulsing `done`.
- R4: A frame request (`req_ctrl`=0) shifts, with `disp_rs` low, the buffer bytes at `req_base`, `req_base+1`, … up to `req_base+NBYTES-1` in increasing address order. Each byte goes bit 7 first and bit 0 last, so the leftmost character's first column leads.
- R5: A control request (`req_ctrl`=1) shifts `req_byte` unchanged, bit 7 first, with `disp_rs` high.
- R6: `disp_rs` takes its value at least T_GAP cycles before `disp_ce_n` falls and holds it while `disp_ce_n` is low. `disp_ce_n` falls only while `disp_sclk` is low.
- R7: While `disp_ce_n` is low, each high phase of `disp_sclk` lasts exactly T_HI cycles, and each rising edge follows at least T_LO low cycles. `disp_sdat` carries the bit sampled at that rising edge.
- R8: A transfer ends by raising `disp_ce_n` while `disp_sclk` is high, then lowering `disp_sclk` exactly T_GAP cycles later (the latch edge).
- R9: A request is accepted only while `busy` is low, and `busy` is high on the next cycle. `done` pulses for one cycle, with `busy` low, once per accepted request. `req_valid` asserted while busy has no effect.
- R10: `disp_sclk` rises only while `disp_ce_n` is low, and while idle `disp_ce_n` is high and `disp_sclk` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_ctrl | input | 1 | 1 = control write, 0 = frame load |
| req_base | input | ADDR_W | Frame start address in the column buffer |
| req_byte | input | 8 | Control byte for a control write |
| busy | output | 1 | High from acceptance until the transfer is latched |
| done | output | 1 | One-cycle pulse at the end of a requested transfer |
| buf_addr | output | ADDR_W | Column buffer read address |
| buf_data | input | 8 | Column buffer byte at `buf_addr` (combinational read) |
| disp_rst_n | output | 1 | Device reset, active low |
| disp_ce_n | output | 1 | Device enable, active low |
| disp_rs | output | 1 | Register select: 1 = control, 0 = dot data |
| disp_sclk | output | 1 | Serial clock to the devices |
| disp_sdat | output | 1 | Serial data to the devices |

## Verification
The bench builds the block with one device of two characters of three columns each. That makes a six-byte, 48-bit frame, with a 16-byte buffer and timing values of two to five cycles. At this size every one of the 256 control bytes can be sent, and every legal frame base from 0 to 10 can be loaded under three different buffer patterns. Each transfer is decoded from the pins and compared bit for bit against values the bench computes from the buffer contents. The same small timing values make each phase width, and the gap between an enable edge and the clock edge near it, checkable to the exact cycle.

// File: rtl/dml_pkg.sv
package dml_pkg;

    typedef enum logic [2:0] {
        ST_RESET_PULSE,
        ST_RS_SETUP,
        ST_CE_FALL,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_CE_RISE,
        ST_LATCH,
        ST_IDLE
    } dml_state_e;

    typedef enum logic [1:0] {
        K_CLEAR,
        K_FRAME,
        K_CTRL
    } dml_kind_e;

endpackage

// File: rtl/dml_timer.sv
module dml_timer #(
    parameter int CW      = 4,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CW'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/dml_byte_shifter.sv
module dml_byte_shifter #(
    parameter int BYTE_CW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               first,
    input  logic               next,
    input  logic               shift,
    input  logic [7:0]         din,
    output logic               msb,
    output logic               bit_last,
    output logic [BYTE_CW-1:0] byte_idx
);

    logic [7:0]         sh_q;
    logic [2:0]         bit_q;
    logic [BYTE_CW-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bit_q  <= '0;
            byte_q <= '0;
        end else if (first) begin
            sh_q   <= din;
            bit_q  <= '0;
            byte_q <= '0;
        end else if (next) begin
            sh_q   <= din;
            bit_q  <= '0;
            byte_q <= byte_q + 1'b1;
        end else if (shift) begin
            sh_q   <= {sh_q[6:0], 1'b0};
            bit_q  <= bit_q + 1'b1;
        end
    end

    assign msb      = sh_q[7];
    assign bit_last = (bit_q == 3'd7);
    assign byte_idx = byte_q;

endmodule

// File: rtl/dotmatrix_loader.sv
module dotmatrix_loader #(
    parameter int         N_DEV         = 2,
    parameter int         CHARS_PER_DEV = 4,
    parameter int         COLS_PER_CHAR = 5,
    parameter int         ADDR_W        = 8,
    parameter int         T_RST         = 8,
    parameter int         T_HI          = 10,
    parameter int         T_LO          = 10,
    parameter int         T_GAP         = 4,
    parameter logic [5:0] BOOT_LEVEL    = 6'h2F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ctrl,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [7:0]        req_byte,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    output logic              disp_rst_n,
    output logic              disp_ce_n,
    output logic              disp_rs,
    output logic              disp_sclk,
    output logic              disp_sdat
);
    import dml_pkg::*;

    localparam int NBYTES  = N_DEV * CHARS_PER_DEV * COLS_PER_CHAR;
    localparam int BYTE_CW = $clog2(NBYTES + 1);
    localparam int TMAX_A  = (T_HI > T_LO) ? T_HI : T_LO;
    localparam int TMAX_B  = (T_GAP > T_RST) ? T_GAP : T_RST;
    localparam int TMAX    = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TCW     = $clog2(TMAX + 1);

    dml_state_e        state_q, state_d;
    dml_kind_e         kind_q;
    logic [7:0]        ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic              booting_q, done_q;

    logic              tmr_load, tmr_zero;
    logic [TCW-1:0]    tmr_val;
    logic              sh_first, sh_next, sh_shift;
    logic              sh_msb, sh_bit_last;
    logic [BYTE_CW-1:0] sh_byte;
    logic              last_bit;
    logic              accept, boot_ctrl, finish;
    logic [7:0]        byte_src;

    function automatic logic [TCW-1:0] phase_len(input dml_state_e st);
        unique case (st)
            ST_RESET_PULSE: phase_len = TCW'(T_RST - 1);
            ST_CLK_LOW:     phase_len = TCW'(T_LO - 1);
            ST_LATCH:       phase_len = TCW'(T_LO - 1);
            ST_CLK_HIGH:    phase_len = TCW'(T_HI - 1);
            ST_RS_SETUP,
            ST_CE_FALL,
            ST_CE_RISE:     phase_len = TCW'(T_GAP - 1);
            ST_IDLE:        phase_len = '0;
        endcase
    endfunction

    dml_timer #(.CW(TCW), .RST_VAL(T_RST - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dml_byte_shifter #(.BYTE_CW(BYTE_CW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .first    (sh_first),
        .next     (sh_next),
        .shift    (sh_shift),
        .din      (byte_src),
        .msb      (sh_msb),
        .bit_last (sh_bit_last),
        .byte_idx (sh_byte)
    );

    always_comb begin
        unique case (kind_q)
            K_CTRL:  byte_src = ctrl_q;
            K_FRAME: byte_src = buf_data;
            default: byte_src = 8'h00;
        endcase
    end

    assign last_bit = sh_bit_last &&
        ((kind_q == K_CTRL) ? (sh_byte == '0) : (sh_byte == BYTE_CW'(NBYTES - 1)));

    // next-state logic
    always_comb begin
        state_d   = state_q;
        sh_first  = 1'b0;
        sh_next   = 1'b0;
        sh_shift  = 1'b0;
        accept    = 1'b0;
        boot_ctrl = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_RESET_PULSE: if (tmr_zero) state_d = ST_RS_SETUP;
            ST_RS_SETUP:    if (tmr_zero) state_d = ST_CE_FALL;
            ST_CE_FALL: if (tmr_zero) begin
                state_d  = ST_CLK_LOW;
                sh_first = 1'b1;
            end
            ST_CLK_LOW:     if (tmr_zero) state_d = ST_CLK_HIGH;
            ST_CLK_HIGH: if (tmr_zero) begin
                if (last_bit) begin
                    state_d = ST_CE_RISE;
                end else begin
                    state_d  = ST_CLK_LOW;
                    sh_next  = sh_bit_last;
                    sh_shift = !sh_bit_last;
                end
            end
            ST_CE_RISE:     if (tmr_zero) state_d = ST_LATCH;
            ST_LATCH: if (tmr_zero) begin
                if (booting_q && kind_q == K_CLEAR) begin
                    state_d   = ST_RS_SETUP;
                    boot_ctrl = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_IDLE: if (req_valid) begin
                state_d = ST_RS_SETUP;
                accept  = 1'b1;
            end
        endcase
        tmr_load = (state_d != state_q);
        tmr_val  = phase_len(state_d);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RESET_PULSE;
            kind_q    <= K_CLEAR;
            ctrl_q    <= '0;
            addr_q    <= '0;
            booting_q <= 1'b1;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish && !booting_q;
            if (finish)
                booting_q <= 1'b0;
            if (accept) begin
                kind_q <= req_ctrl ? K_CTRL : K_FRAME;
                ctrl_q <= req_byte;
                addr_q <= req_base;
            end else if (sh_first || sh_next) begin
                addr_q <= addr_q + 1'b1;
            end
            if (boot_ctrl) begin
                kind_q <= K_CTRL;
                ctrl_q <= {2'b01, BOOT_LEVEL};
            end
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        buf_addr   = addr_q;
        disp_rst_n = (state_q != ST_RESET_PULSE);
        disp_ce_n  = !(state_q == ST_CE_FALL || state_q == ST_CLK_LOW ||
                       state_q == ST_CLK_HIGH);
        disp_sclk  = (state_q == ST_CLK_HIGH || state_q == ST_CE_RISE);
        disp_sdat  = (state_q == ST_CLK_LOW || state_q == ST_CLK_HIGH) && sh_msb;
        disp_rs    = (kind_q == K_CTRL);
    end

endmodule

// File: rtl/dml_checker.sv
module dml_checker #(
    parameter int T_HI = 10
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic disp_rst_n,
    input logic disp_ce_n,
    input logic disp_rs,
    input logic disp_sclk
);

    logic [7:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (disp_sclk)
            hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
        else
            hi_cnt <= '0;
    end

    assert_rst_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(disp_rst_n));

    assert_ce_fall_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_ce_n) |-> !disp_sclk);

    assert_rs_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ce_n && !$past(disp_ce_n)) |-> $stable(disp_rs));

    assert_high_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(disp_sclk) && !disp_ce_n) |-> (hi_cnt == 8'(T_HI)));

    assert_ce_rise_clk_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_ce_n) |-> disp_sclk);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (disp_ce_n && !disp_sclk));

    assert_rise_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_sclk) |-> !disp_ce_n);

endmodule

bind dotmatrix_loader dml_checker #(.T_HI(T_HI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .disp_rst_n (disp_rst_n),
    .disp_ce_n  (disp_ce_n),
    .disp_rs    (disp_rs),
    .disp_sclk  (disp_sclk)
);

// File: tb/sim_dotmatrix_loader.sv
module sim_dotmatrix_loader;

    localparam int         AW  = 4;
    localparam int         TR  = 5;
    localparam int         TH  = 2;
    localparam int         TL  = 3;
    localparam int         TG  = 2;
    localparam logic [5:0] LVL = 6'h2D;
    localparam int         NB  = 6;
    localparam int         NBITS = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ctrl;
    logic [AW-1:0] req_base;
    logic [7:0]    req_byte;
    logic          busy, done;
    logic [AW-1:0] buf_addr;
    logic [7:0]    buf_data;
    logic          disp_rst_n, disp_ce_n, disp_rs, disp_sclk, disp_sdat;
    logic [7:0]    mem [0:15];

    always #5 clk = ~clk;
    assign buf_data = mem[buf_addr];

    dotmatrix_loader #(
        .N_DEV(1), .CHARS_PER_DEV(2), .COLS_PER_CHAR(3), .ADDR_W(AW),
        .T_RST(TR), .T_HI(TH), .T_LO(TL), .T_GAP(TG), .BOOT_LEVEL(LVL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctrl(req_ctrl),
        .req_base(req_base), .req_byte(req_byte), .busy(busy), .done(done),
        .buf_addr(buf_addr), .buf_data(buf_data), .disp_rst_n(disp_rst_n),
        .disp_ce_n(disp_ce_n), .disp_rs(disp_rs), .disp_sclk(disp_sclk),
        .disp_sdat(disp_sdat)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pin-level decoder
    logic        p_sclk = 1'b0, p_ce = 1'b1, p_rs = 1'b0, rs_at_fall = 1'b0;
    int          hi_run = 0, lo_run = 0, ce_run = 0, rs_run = 0, ncap = 0;
    int          ev_count = 0, done_cnt = 0, ev_n = 0;
    logic        ev_rs = 1'b0;
    logic [63:0] act_v = '0, ev_v = '0;
    logic        h_rs [0:1];
    int          h_n  [0:1];
    logic [63:0] h_v  [0:1];

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (!p_sclk && disp_sclk) begin
                chk(!disp_ce_n, "R10 clock rise with enable low", 64'(disp_ce_n), 0);
                chk(lo_run >= TL, "R7 low phase width", 64'(lo_run), 64'(TL));
                act_v = {act_v[62:0], disp_sdat};
                ncap++;
            end
            if (p_sclk && !disp_sclk) begin
                if (!disp_ce_n) begin
                    chk(hi_run == TH, "R7 high phase width", 64'(hi_run), 64'(TH));
                end else begin
                    chk(ce_run == TG, "R8 latch edge delay", 64'(ce_run), 64'(TG));
                    chk(disp_rs == rs_at_fall, "R6 select held", 64'(disp_rs), 64'(rs_at_fall));
                    ev_rs = disp_rs;
                    ev_n  = ncap;
                    ev_v  = act_v;
                    if (ev_count < 2) begin
                        h_rs[ev_count] = ev_rs;
                        h_n[ev_count]  = ev_n;
                        h_v[ev_count]  = ev_v;
                    end
                    ev_count++;
                end
            end
            if (p_ce && !disp_ce_n) begin
                chk(!disp_sclk, "R6 enable falls with clock low", 64'(disp_sclk), 0);
                chk(rs_run >= TG, "R6 select setup", 64'(rs_run), 64'(TG));
                rs_at_fall = disp_rs;
                ncap  = 0;
                act_v = '0;
            end
            if (!p_ce && disp_ce_n)
                chk(disp_sclk, "R8 enable rises with clock high", 64'(disp_sclk), 1);
            hi_run = disp_sclk ? (p_sclk ? hi_run + 1 : 1) : 0;
            lo_run = !disp_sclk ? (!p_sclk ? lo_run + 1 : 1) : 0;
            ce_run = disp_ce_n ? (p_ce ? ce_run + 1 : 1) : 0;
            rs_run = (disp_rs == p_rs) ? rs_run + 1 : 1;
            p_sclk = disp_sclk;
            p_ce   = disp_ce_n;
            p_rs   = disp_rs;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic issue(input bit ctl, input logic [AW-1:0] base, input logic [7:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_ctrl = ctl; req_base = base; req_byte = b;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R9 busy after accept", 64'(busy), 1);
        wait_done();
        chk(!busy, "R9 idle when done pulses", 64'(busy), 0);
        @(negedge clk);
        chk(!done, "R9 done lasts one cycle", 64'(done), 0);
    endtask

    function automatic logic [63:0] frame_exp(input int base);
        logic [63:0] v = '0;
        for (int i = 0; i < NB; i++)
            for (int b = 7; b >= 0; b--)
                v = {v[62:0], mem[base + i][b]};
        return v;
    endfunction

    initial begin
        int n;
        int snap;
        rst_n = 1'b0; req_valid = 1'b0; req_ctrl = 1'b0; req_base = '0; req_byte = '0;
        for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk(!disp_rst_n && busy && disp_ce_n && !disp_sclk, "R1 reset state",
            {60'd0, disp_rst_n, busy, disp_ce_n, disp_sclk}, 64'h6);
        rst_n = 1'b1;
        n = 0;
        while (!disp_rst_n) begin
            n++;
            @(negedge clk);
        end
        chk(n == TR, "R1 device reset width", 64'(n), 64'(TR));
        while (busy) @(negedge clk);
        chk(ev_count == 2, "R3 start-up transfer count", 64'(ev_count), 2);
        chk(done_cnt == 0, "R3 no done during start-up", 64'(done_cnt), 0);
        chk(h_rs[0] == 1'b0 && h_n[0] == NBITS, "R2 clear select and length",
            {h_rs[0], 63'(h_n[0])}, 64'(NBITS));
        chk(h_v[0] == 64'd0, "R2 clear data all zero", h_v[0], 0);
        chk(h_rs[1] == 1'b1 && h_n[1] == 8, "R3 wake write select and length",
            {h_rs[1], 63'(h_n[1])}, {1'b1, 63'd8});
        chk(h_v[1][7:0] == {2'b01, LVL}, "R3 wake control word",
            64'(h_v[1][7:0]), 64'({2'b01, LVL}));

        // frame sweep: every legal base under three buffer patterns
        for (int s = 0; s < 3; s++) begin
            for (int i = 0; i < 16; i++) begin
                case (s)
                    0: mem[i] = 8'(i * 29 + 7);
                    1: mem[i] = 8'h01 << (i % 8);
                    default: mem[i] = ~8'(i * 53);
                endcase
            end
            for (int base = 0; base <= 16 - NB; base++) begin
                snap = ev_count;
                issue(1'b0, AW'(base), 8'h00);
                chk(ev_count == snap + 1, "R9 one transfer per frame request",
                    64'(ev_count - snap), 1);
                chk(ev_rs == 1'b0 && ev_n == NBITS, "R4 frame select and length",
                    {ev_rs, 63'(ev_n)}, 64'(NBITS));
                chk(ev_v[NBITS-1:0] == frame_exp(base), "R4 frame bit order",
                    64'(ev_v[NBITS-1:0]), frame_exp(base));
            end
        end

        // exhaustive control byte sweep
        for (int v = 0; v < 256; v++) begin
            issue(1'b1, '0, 8'(v));
            chk(ev_rs == 1'b1 && ev_n == 8, "R5 control select and length",
                {ev_rs, 63'(ev_n)}, {1'b1, 63'd8});
            chk(ev_v[7:0] == 8'(v), "R5 control byte", 64'(ev_v[7:0]), 64'(v));
        end

        // request held while busy is ignored
        snap = ev_count;
        @(negedge clk);
        req_valid = 1'b1; req_ctrl = 1'b1; req_byte = 8'hA5;
        @(negedge clk);
        req_ctrl = 1'b0; req_base = 4'd3; req_byte = 8'h00;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        chk(ev_count == snap + 1, "R9 request while busy ignored", 64'(ev_count - snap), 1);
        chk(!busy && ev_rs && ev_v[7:0] == 8'hA5, "R9 accepted request intact",
            {busy, ev_rs, 54'd0, ev_v[7:0]}, {1'b0, 1'b1, 54'd0, 8'hA5});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule